// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits between a set of divided clocks and their output buffers and decides, per output, whether the clock reaches the buffer. Two requests can halt clocks. The first is an asynchronous active-low power-down input, which is confirmed in the CPU clock domain and then parks every output. The second is a software stop bit, which halts the PCI-class clocks and any free-running PCI or SRC output whose stop mask is set. Every output also has its own enable bit. Each differential pair has drive-mode bits that choose between a driven park level and three-state.

Every halt or restart takes effect on a falling edge of that output's own clock. As a result, a clock can only stop after a complete high phase, and the first high phase after a restart is complete as well. The asynchronous requests are resynchronised in each domain before they are used. A `pllPd` flag tells the analog section that the PLLs and VCO may shut down. Output drive strength and current-mode signalling are modelled only as data values and output-enable flags.

Top module: `clkpd_top`

## Requirements
- R1: Power-down is confirmed, and `pllPd` set to 1, only after `pdN` has been sampled low on two consecutive rising edges of `cpuClk`. A low seen on a single rising edge has no effect.
- R2: While `pdN` stays low, a confirmed power-down holds. `pllPd` returns to 0 on the first rising edge of `cpuClk` that samples `pdN` high.
- R3: Once power-down is confirmed, `pciOut`, `pcifOut`, `refOut` and `srcT` are each held at 0, starting from a falling edge of their own clock. No gated output ever produces a high phase shorter than its source clock's high phase.
- R4: On the `cpuClk` falling edge that follows the confirming rising edge, every CPU pair parks with the following levels:
  - `cpuT` = 1 and `cpuCOe` = 0.
  - `cpuTOe[i]` = 1 when `cpuPdTri[i]` = 0, and 0 when `cpuPdTri[i]` = 1.
- R5: In power-down, the SRC pair behaves as follows:
  - `srcOe` = 0 when `srcPdTri` = 1.
  - Otherwise `srcOe` = 1, `srcT` = 0 and `srcC` = 1.
- R6: The effect of `swStopN` = 0 depends on the output:
  - Every `pciOut` halts.
  - `pcifOut[i]` halts only when `pcifStopMask[i]` = 1, and SRC halts only when `srcStopMask` = 1.
  - Unmasked PCIF outputs, the CPU pairs and `refOut` keep toggling.
- R7: While SRC is halted by the software stop, `srcOe` = 0 when `srcStopTri` = 1. When `srcStopTri` = 0, the pair is driven with `srcT` = 0 and `srcC` = 1.
- R8: When the halt request is released (`pdN` or `swStopN` back to 1), every halted output resumes toggling. Its first high phase is full width.
- R9: Each enable bit acts on its own output only:
  - A single-ended output whose enable bit is 0 is held at 0.
  - A CPU pair whose enable bit is 0 has `cpuTOe` = 0 and `cpuCOe` = 0.
  - All other outputs are unaffected.
- R10: While `rstN` is low, `pllPd` = 0 and every single-ended output is 0. After reset is released, each enabled output begins toggling once its synchroniser has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | CPU-domain source clock; also samples `pdN` |
| srcClk | input | 1 | SRC-domain source clock |
| pciClk | input | 1 | Source clock for PCI and free-running PCI outputs |
| refClk | input | 1 | Reference-domain source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Asynchronous active-low power-down request |
| swStopN | input | 1 | Software stop bit, 0 = stop |
| cpuEn | input | NCPU (3) | Per-pair CPU enable |
| cpuPdTri | input | NCPU (3) | Per-pair CPU power-down mode, 1 = three-state true leg |
| srcEn | input | 1 | SRC pair enable |
| srcStopMask | input | 1 | 1 = SRC halts with the software stop |
| srcStopTri | input | 1 | 1 = SRC three-state while software-stopped |
| srcPdTri | input | 1 | 1 = SRC three-state in power-down |
| pciEn | input | NPCI (6) | Per-output PCI enable |
| pcifEn | input | NPCIF (3) | Per-output free-running PCI enable |
| pcifStopMask | input | NPCIF (3) | 1 = that output halts with the software stop |
| refEn | input | NREF (2) | Per-output reference enable |
| cpuT | output | NCPU (3) | CPU true legs |
| cpuC | output | NCPU (3) | CPU complement legs |
| cpuTOe | output | NCPU (3) | Drive enable of the true legs |
| cpuCOe | output | NCPU (3) | Drive enable of the complement legs |
| srcT | output | 1 | SRC true leg |
| srcC | output | 1 | SRC complement leg |
| srcOe | output | 1 | SRC pair drive enable |
| pciOut | output | NPCI (6) | Gated PCI clocks |
| pcifOut | output | NPCIF (3) | Gated free-running PCI clocks |
| refOut | output | NREF (2) | Gated reference clocks |
| pllPd | output | 1 | Power-down confirmed; PLLs and VCO may shut off |

## Verification
The embedded properties relate each gate's state to its halt request two rising edges earlier. They also relate `pllPd` to `pdN` on the previous rising edges. Both relations assume that no request changes on a clock edge of the domain that samples it. The stimulus respects this by changing every input 0.5 ns after a `cpuClk` falling edge. Every source period is a multiple of 5 ns, so that instant never coincides with an edge of any domain. Request changes are also held for many slow-domain cycles, so each synchroniser settles before the outputs are observed.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  // Strobes from the control section to the gating datapath
  typedef struct packed {
    logic pdReq;    // power-down confirmed, cpuClk domain
    logic stopReq;  // software stop, asynchronous to every gate domain
  } gateStrobe_t;

  localparam int SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/clkpd_gate.sv
// One gate state: the halt request is resynchronised on rising edges,
// and the run flag changes only on falling edges of the same clock.
module clkpd_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic haltReq,
  output logic running
);

  logic haltSync;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign haltSync = haltReq;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] stages;
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) stages <= '1;
        else       stages <= (stages << 1) | SYNC_STAGES'(haltReq);
      end
      assign haltSync = stages[SYNC_STAGES-1];
    end
  endgenerate

  // Falling-edge update: output is low whenever the flag moves
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= ~haltSync;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
      end

      // R3
      halt_takes_effect_chk: assert property (@(posedge clkIn) disable iff (!rstN)
        (age == 2'd3) && $past(haltReq, 2) |-> !running);

      // R8
      release_takes_effect_chk: assert property (@(posedge clkIn) disable iff (!rstN)
        (age == 2'd3) && !$past(haltReq, 2) |-> running);
    end
  endgenerate

endmodule

// File: rtl/clkpd_ctrl.sv
// Confirms power-down in the CPU domain and packs the request strobes.
module clkpd_ctrl
  import clkpd_pkg::*;
(
  input  logic        cpuClk,
  input  logic        rstN,
  input  logic        pdN,
  input  logic        swStopN,
  output gateStrobe_t strobe,
  output logic        pllPd
);

  logic lowSeen;
  logic pdActive;

  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      lowSeen  <= 1'b0;
      pdActive <= 1'b0;
    end else begin
      lowSeen <= ~pdN;
      if (pdN)          pdActive <= 1'b0;
      else if (lowSeen) pdActive <= 1'b1;
    end
  end

  assign strobe.pdReq   = pdActive;
  assign strobe.stopReq = ~swStopN;
  assign pllPd          = pdActive;

  // R1
  pd_needs_two_lows_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    $rose(pllPd) |-> (!$past(pdN) && !$past(pdN, 2)));

  // R2
  pd_holds_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    pllPd && !pdN |=> pllPd);

  // R2
  pd_release_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    pllPd && pdN |=> !pllPd);

endmodule

// File: rtl/clkpd_path.sv
// Gating datapath: one gate state per domain group and per output.
module clkpd_path
  import clkpd_pkg::*;
#(
  parameter int NCPU        = 3,
  parameter int NPCI        = 6,
  parameter int NPCIF       = 3,
  parameter int NREF        = 2,
  parameter int SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
  input  logic             cpuClk,
  input  logic             srcClk,
  input  logic             pciClk,
  input  logic             refClk,
  input  logic             rstN,
  input  gateStrobe_t      strobe,
  input  logic [NCPU-1:0]  cpuEn,
  input  logic [NCPU-1:0]  cpuPdTri,
  input  logic             srcEn,
  input  logic             srcStopMask,
  input  logic             srcStopTri,
  input  logic             srcPdTri,
  input  logic [NPCI-1:0]  pciEn,
  input  logic [NPCIF-1:0] pcifEn,
  input  logic [NPCIF-1:0] pcifStopMask,
  input  logic [NREF-1:0]  refEn,
  output logic [NCPU-1:0]  cpuT,
  output logic [NCPU-1:0]  cpuC,
  output logic [NCPU-1:0]  cpuTOe,
  output logic [NCPU-1:0]  cpuCOe,
  output logic             srcT,
  output logic             srcC,
  output logic             srcOe,
  output logic [NPCI-1:0]  pciOut,
  output logic [NPCIF-1:0] pcifOut,
  output logic [NREF-1:0]  refOut
);

  // CPU pairs: request is already in the cpuClk domain
  logic cpuRun;
  clkpd_gate #(.SYNC_STAGES(0)) u_cpuGate (
    .clkIn(cpuClk), .rstN(rstN), .haltReq(strobe.pdReq), .running(cpuRun)
  );

  assign cpuT   = {NCPU{cpuClk | ~cpuRun}};
  assign cpuC   = {NCPU{~cpuClk & cpuRun}};
  assign cpuTOe = cpuEn & ~(cpuPdTri & {NCPU{~cpuRun}});
  assign cpuCOe = cpuEn & {NCPU{cpuRun}};

  // SRC pair: halted low-true / high-complement when driven
  logic srcRun;
  logic srcTriNow;
  clkpd_gate #(.SYNC_STAGES(SYNC_STAGES)) u_srcGate (
    .clkIn(srcClk), .rstN(rstN),
    .haltReq(strobe.pdReq | (strobe.stopReq & srcStopMask)),
    .running(srcRun)
  );

  assign srcTriNow = ~srcRun & (strobe.pdReq ? srcPdTri : srcStopTri);
  assign srcT      = srcClk & srcRun;
  assign srcC      = ~srcT;
  assign srcOe     = srcEn & ~srcTriNow;

  // PCI: always stoppable
  logic [NPCI-1:0] pciRun;
  for (genvar g = 0; g < NPCI; g++) begin : g_pci
    clkpd_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clkIn(pciClk), .rstN(rstN),
      .haltReq(strobe.pdReq | strobe.stopReq | ~pciEn[g]),
      .running(pciRun[g])
    );
    assign pciOut[g] = pciClk & pciRun[g];
  end

  // Free-running PCI: stoppable per mask
  logic [NPCIF-1:0] pcifRun;
  for (genvar g = 0; g < NPCIF; g++) begin : g_pcif
    clkpd_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clkIn(pciClk), .rstN(rstN),
      .haltReq(strobe.pdReq | (strobe.stopReq & pcifStopMask[g]) | ~pcifEn[g]),
      .running(pcifRun[g])
    );
    assign pcifOut[g] = pciClk & pcifRun[g];
  end

  // Reference: power-down and enable only
  logic [NREF-1:0] refRun;
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    clkpd_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clkIn(refClk), .rstN(rstN),
      .haltReq(strobe.pdReq | ~refEn[g]),
      .running(refRun[g])
    );
    assign refOut[g] = refClk & refRun[g];
  end

endmodule

// File: rtl/clkpd_top.sv
module clkpd_top
  import clkpd_pkg::*;
#(
  parameter int NCPU        = 3,
  parameter int NPCI        = 6,
  parameter int NPCIF       = 3,
  parameter int NREF        = 2,
  parameter int SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
  input  logic             cpuClk,
  input  logic             srcClk,
  input  logic             pciClk,
  input  logic             refClk,
  input  logic             rstN,
  input  logic             pdN,
  input  logic             swStopN,
  input  logic [NCPU-1:0]  cpuEn,
  input  logic [NCPU-1:0]  cpuPdTri,
  input  logic             srcEn,
  input  logic             srcStopMask,
  input  logic             srcStopTri,
  input  logic             srcPdTri,
  input  logic [NPCI-1:0]  pciEn,
  input  logic [NPCIF-1:0] pcifEn,
  input  logic [NPCIF-1:0] pcifStopMask,
  input  logic [NREF-1:0]  refEn,
  output logic [NCPU-1:0]  cpuT,
  output logic [NCPU-1:0]  cpuC,
  output logic [NCPU-1:0]  cpuTOe,
  output logic [NCPU-1:0]  cpuCOe,
  output logic             srcT,
  output logic             srcC,
  output logic             srcOe,
  output logic [NPCI-1:0]  pciOut,
  output logic [NPCIF-1:0] pcifOut,
  output logic [NREF-1:0]  refOut,
  output logic             pllPd
);

  gateStrobe_t strobe;

  clkpd_ctrl u_ctrl (
    .cpuClk(cpuClk), .rstN(rstN), .pdN(pdN), .swStopN(swStopN),
    .strobe(strobe), .pllPd(pllPd)
  );

  clkpd_path #(
    .NCPU(NCPU), .NPCI(NPCI), .NPCIF(NPCIF), .NREF(NREF), .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .cpuClk(cpuClk), .srcClk(srcClk), .pciClk(pciClk), .refClk(refClk),
    .rstN(rstN), .strobe(strobe),
    .cpuEn(cpuEn), .cpuPdTri(cpuPdTri),
    .srcEn(srcEn), .srcStopMask(srcStopMask), .srcStopTri(srcStopTri), .srcPdTri(srcPdTri),
    .pciEn(pciEn), .pcifEn(pcifEn), .pcifStopMask(pcifStopMask), .refEn(refEn),
    .cpuT(cpuT), .cpuC(cpuC), .cpuTOe(cpuTOe), .cpuCOe(cpuCOe),
    .srcT(srcT), .srcC(srcC), .srcOe(srcOe),
    .pciOut(pciOut), .pcifOut(pcifOut), .refOut(refOut)
  );

endmodule

// File: tb/sim_clkpd_top.sv
module sim_clkpd_top;
  timeunit 1ns;
  timeprecision 10ps;

  logic cpuClk = 1'b0, srcClk = 1'b0, pciClk = 1'b0, refClk = 1'b0;
  logic rstN = 1'b0, pdN = 1'b1, swStopN = 1'b1;
  logic [2:0] cpuEn = 3'b111, cpuPdTri = 3'b000;
  logic srcEn = 1'b1, srcStopMask = 1'b0, srcStopTri = 1'b0, srcPdTri = 1'b0;
  logic [5:0] pciEn = 6'h3F;
  logic [2:0] pcifEn = 3'b111, pcifStopMask = 3'b000;
  logic [1:0] refEn = 2'b11;
  logic [2:0] cpuT, cpuC, cpuTOe, cpuCOe;
  logic srcT, srcC, srcOe, pllPd;
  logic [5:0] pciOut;
  logic [2:0] pcifOut;
  logic [1:0] refOut;

  always #2.5 cpuClk = ~cpuClk;   // 200 MHz
  always #5   srcClk = ~srcClk;
  always #15  pciClk = ~pciClk;
  always #35  refClk = ~refClk;

  clkpd_top u0 (
    .cpuClk, .srcClk, .pciClk, .refClk, .rstN, .pdN, .swStopN,
    .cpuEn, .cpuPdTri, .srcEn, .srcStopMask, .srcStopTri, .srcPdTri,
    .pciEn, .pcifEn, .pcifStopMask, .refEn,
    .cpuT, .cpuC, .cpuTOe, .cpuCOe, .srcT, .srcC, .srcOe,
    .pciOut, .pcifOut, .refOut, .pllPd
  );

  // Bit map: ref 0-1, pci 2-7, pcif 8-10, srcT 11, cpuT 12-14
  wire [14:0] obs = {cpuT, srcT, pcifOut, pciOut, refOut};
  localparam logic [14:0] ALL = 15'h7FFF;

  int checks = 0, errors = 0, runtCnt = 0;
  int riseCnt [15];
  int snap    [15];
  int runLen  [15];
  bit done = 1'b0;

  function automatic int halfSamples(input int i);
    if (i < 2)   return 70;
    if (i < 11)  return 30;
    if (i == 11) return 10;
    return 5;
  endfunction

  // Sampler at 0.5 ns steps, offset from every clock edge
  initial begin
    logic [14:0] prev;
    prev = '0;
    for (int i = 0; i < 15; i++) begin riseCnt[i] = 0; runLen[i] = 0; end
    #0.25;
    forever begin
      for (int i = 0; i < 15; i++) begin
        if (obs[i]) begin
          runLen[i]++;
          if (!prev[i]) riseCnt[i]++;
        end else begin
          if (prev[i] && runLen[i] < halfSamples(i)) runtCnt++;
          runLen[i] = 0;
        end
      end
      prev = obs;
      #0.5;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic align();
    @(negedge cpuClk);
    #0.5;
  endtask

  task automatic measure(input int ns);
    for (int i = 0; i < 15; i++) snap[i] = riseCnt[i];
    #ns;
  endtask

  task automatic expectRun(input logic [14:0] runMask, input string req);
    for (int i = 0; i < 15; i++) begin
      int d;
      d = riseCnt[i] - snap[i];
      if (runMask[i]) chk(d > 0,  req, $sformatf("bit %0d toggles", i), d, 1);
      else            chk(d == 0, req, $sformatf("bit %0d halted", i), d, 0);
    end
  endtask

  task automatic tReset();
    #20;
    chk(pllPd == 1'b0, "R10", "pllPd in reset", pllPd, 0);
    chk(obs[10:0] == '0, "R10", "single-ended in reset", obs[10:0], 0);
    align();
    rstN = 1'b1;
    #400;
    measure(400);
    expectRun(ALL, "R10");
  endtask

  task automatic tPdGlitch();
    bit seen;
    seen = 1'b0;
    align();
    pdN = 1'b0;
    align();
    pdN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (pllPd) seen = 1'b1;
      align();
    end
    chk(!seen, "R1", "single low sample ignored", seen, 0);
  endtask

  task automatic tPowerDown();
    cpuPdTri = 3'b010;
    srcPdTri = 1'b1;
    align();
    pdN = 1'b0;
    align();
    chk(pllPd == 1'b0, "R1", "pllPd after first low edge", pllPd, 0);
    chk(cpuT == 3'b000, "R1", "cpuT still running", cpuT, 0);
    align();
    chk(pllPd == 1'b1, "R1", "pllPd after second low edge", pllPd, 1);
    chk(cpuT == 3'b111, "R4", "cpuT parked high", cpuT, 7);
    chk(cpuCOe == 3'b000, "R4", "cpuCOe undriven", cpuCOe, 0);
    chk(cpuTOe == 3'b101, "R4", "cpuTOe per drive mode", cpuTOe, 5);
    #300;
    measure(400);
    expectRun('0, "R3");
    chk(obs[10:0] == '0, "R3", "single-ended held low", obs[10:0], 0);
    chk(srcT == 1'b0, "R3", "srcT held low", srcT, 0);
    chk(srcOe == 1'b0, "R5", "SRC three-state in pd", srcOe, 0);
    chk(pllPd == 1'b1, "R2", "pd holds while low", pllPd, 1);
    srcPdTri = 1'b0;
    #1;
    chk(srcOe && !srcT && srcC, "R5", "SRC driven park {oe,t,c}",
        {srcOe, srcT, srcC}, 3'b101);
    align();
    pdN = 1'b1;
    align();
    chk(pllPd == 1'b0, "R2", "pllPd cleared on release", pllPd, 0);
    #300;
    measure(400);
    expectRun(ALL, "R8");
    cpuPdTri = 3'b000;
  endtask

  task automatic tSwStop();
    logic [14:0] m;
    align();
    pcifStopMask = 3'b101;
    srcStopMask = 1'b1;
    srcStopTri = 1'b0;
    swStopN = 1'b0;
    #300;
    measure(400);
    m = ALL & ~(15'h3F << 2) & ~(15'b1 << 8) & ~(15'b1 << 10) & ~(15'b1 << 11);
    expectRun(m, "R6");
    chk(pciOut == '0, "R6", "pci held low", pciOut, 0);
    chk(srcOe && !srcT && srcC, "R7", "SRC driven stop {oe,t,c}",
        {srcOe, srcT, srcC}, 3'b101);
    srcStopTri = 1'b1;
    #1;
    chk(srcOe == 1'b0, "R7", "SRC three-state in stop", srcOe, 0);
    align();
    swStopN = 1'b1;
    #300;
    measure(400);
    expectRun(ALL, "R8");
    chk(srcOe == 1'b1, "R8", "SRC driven after restart", srcOe, 1);
    pcifStopMask = 3'b000;
    srcStopMask = 1'b0;
    srcStopTri = 1'b0;
  endtask

  task automatic tEnables();
    align();
    pciEn[3] = 1'b0;
    refEn[1] = 1'b0;
    cpuEn[2] = 1'b0;
    #300;
    measure(400);
    expectRun(ALL & ~(15'b1 << 5) & ~(15'b1 << 1), "R9");
    chk(pciOut[3] == 1'b0 && refOut[1] == 1'b0, "R9", "disabled outputs low",
        {pciOut[3], refOut[1]}, 0);
    chk(cpuTOe == 3'b011 && cpuCOe == 3'b011, "R9", "disabled CPU pair oe",
        {cpuTOe, cpuCOe}, 6'b011011);
    align();
    pciEn = 6'h3F;
    refEn = 2'b11;
    cpuEn = 3'b111;
    #300;
    measure(400);
    expectRun(ALL, "R9");
  endtask

  initial begin
    tReset();
    tPdGlitch();
    tPowerDown();
    tSwStop();
    tEnables();
    chk(runtCnt == 0, "R3", "short high phases seen", runtCnt, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule